// File: doc/BRIEF.md
# Free-Fall and Wake-Up Interrupt Generator

This block watches a stream of signed 8-bit motion samples on three axes and decides when to raise an interrupt. Each axis compares the magnitude of its sample with one shared threshold. The result is a "high" event when the magnitude lies above the threshold and a "low" event otherwise. Per-axis enable bits select which of these events take part. A mode bit picks how the enabled events combine:

- OR mode gives wake-up detection: any enabled event is enough.
- AND mode gives free-fall detection: every enabled event must be true, for example all axes low.

The combined condition must persist over a programmable number of consecutive samples before the interrupt-active flag is set. Without latching, the flag follows the condition and drops on the first sample where the condition fails. With latching, the flag and the per-axis source flags freeze until software reads the source register, which is shown here as a read strobe. The interrupt line is a registered copy of the active flag, and its polarity can be selected.

Samples arrive with a one-cycle valid strobe. The rate at which they are produced, and the register bus that supplies the configuration, are outside this block.

Top module: `ffwu_irq_gen`

## Requirements
- R1: After a synchronous reset, the source flags and the active flag are 0, and `irq` equals `irq_active_low`, which is the deasserted level.
- R2: Axis i uses bits [8i+7:8i] of `smp_data` (x=0, y=1, z=2). The axis is high when the magnitude of its two's-complement value is strictly greater than `thresh` (7-bit unsigned), and low otherwise. The value -128 has magnitude 128.
- R3: With `cfg_comb_and`=0 (OR), the condition is true when at least one enabled event is true.
- R4: With `cfg_comb_and`=1 (AND), the condition is true when every enabled event is true.
- R5: When no high-enable or low-enable bit is set, the condition is false in both modes and the active flag never rises.
- R6: The active flag is set on the valid sample that ends a run of `duration`+1 consecutive true samples. A false sample restarts the run. The run counter saturates and does not wrap.
- R7: Without latching, every valid sample loads `src_hi`/`src_lo` with that sample's enabled events (bit i = axis i). The active flag clears on the first valid sample whose condition is false.
- R8: With `cfg_latch`=1, once the active flag is set, both the flag and the source flags hold until a one-cycle `src_rd` pulse, which clears the flag.
- R9: `irq` is `src_active` when `irq_active_low`=0 and its inverse when `irq_active_low`=1. It is registered, so it reflects the polarity one cycle after the polarity changes.
- R10: Only cycles with `smp_valid`=1 are evaluated. Sample changes while the strobe is low have no effect. Results appear after the clock edge that takes the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Three signed samples, x in the low byte |
| cfg_comb_and | input | 1 | 1 = AND combination, 0 = OR |
| cfg_latch | input | 1 | Hold the interrupt until the source register is read |
| cfg_hi_en | input | 3 | Per-axis enables for the high event |
| cfg_lo_en | input | 3 | Per-axis enables for the low event |
| thresh | input | 7 | Magnitude threshold |
| duration | input | 8 | Samples required beyond the first |
| irq_active_low | input | 1 | 1 = active-low interrupt line |
| src_rd | input | 1 | Source register read strobe |
| src_hi | output | 3 | Per-axis high flags |
| src_lo | output | 3 | Per-axis low flags |
| src_active | output | 1 | Interrupt-active flag |
| irq | output | 1 | Interrupt line |

## Verification
The bench drives samples exactly at the threshold and one above it, and it uses negative values including -128. A design that compares signed values, or uses greater-or-equal, flags the wrong axes on these samples. Duration runs of exactly `duration` and `duration`+1 true samples, and a run broken by one false sample, expose off-by-one errors and counters that fail to restart. The bench also covers AND mode with no enables, where a naive reduction would report true, and a latched interrupt followed by false samples and a read, which shows whether the flags hold and then release. Sample changes with the strobe low, and polarity flips, confirm that only qualified samples and the registered polarity move the outputs.

// File: rtl/ffwu_pkg.sv
package ffwu_pkg;
  typedef enum logic {COMB_OR = 1'b0, COMB_AND = 1'b1} comb_mode_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } axis_evt_t;
endpackage

// File: rtl/ffwu_axis_cmp.sv
module ffwu_axis_cmp
  import ffwu_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-2:0] thresh,
  input  logic                en_hi,
  input  logic                en_lo,
  output axis_evt_t           evt
);
  logic [SAMPLE_W-1:0] mag;
  logic                above;

  // magnitude of a two's-complement value; the most negative maps to 2^(W-1)
  assign mag   = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
  assign above = mag > {1'b0, thresh};

  assign evt.hi = en_hi & above;
  assign evt.lo = en_lo & ~above;
endmodule

// File: rtl/ffwu_combine.sv
module ffwu_combine
  import ffwu_pkg::*;
#(
  parameter int NUM_AXES = 3
) (
  input  logic [NUM_AXES-1:0] ev_hi,
  input  logic [NUM_AXES-1:0] ev_lo,
  input  logic [NUM_AXES-1:0] en_hi,
  input  logic [NUM_AXES-1:0] en_lo,
  input  logic                mode_and,
  output logic                cond
);
  localparam int EVW = 2 * NUM_AXES;

  logic [EVW-1:0] ev_all;
  logic [EVW-1:0] en_all;
  logic           any_en;
  logic           or_c;
  logic           and_c;
  comb_mode_e     mode;

  assign ev_all = {ev_hi, ev_lo};
  assign en_all = {en_hi, en_lo};
  assign any_en = |en_all;
  assign or_c   = |ev_all;
  assign and_c  = any_en & (&(ev_all | ~en_all));
  assign mode   = comb_mode_e'(mode_and);

  always_comb begin
    case (mode)
      COMB_AND: cond = and_c;
      default:  cond = or_c;
    endcase
  end

  always_comb begin
    AST_AND_NEEDS_EVENT: assert (!(cond && (mode == COMB_AND) && !or_c)) else $error("AND true without event"); // R4
  end
endmodule

// File: rtl/ffwu_dur_qual.sv
module ffwu_dur_qual #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             cond,
  input  logic [DUR_W-1:0] dur,
  output logic             fire
);
  localparam logic [DUR_W-1:0] CNT_MAX = {DUR_W{1'b1}};

  logic [DUR_W-1:0] run_cnt;

  // the current sample completes a run of run_cnt+1 true samples
  assign fire = valid & cond & (run_cnt >= dur);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (valid) begin
      if (!cond)                run_cnt <= '0;
      else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
    (valid && !cond) |=> (run_cnt == '0)) else $error("run not restarted"); // R6
  AST_RUN_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == CNT_MAX) |=> (run_cnt == CNT_MAX || run_cnt == '0)) else $error("run counter wrapped"); // R6
endmodule

// File: rtl/ffwu_irq_gen.sv
module ffwu_irq_gen
  import ffwu_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int NUM_AXES = 3,
  parameter int DUR_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         smp_valid,
  input  logic [NUM_AXES*SAMPLE_W-1:0] smp_data,
  input  logic                         cfg_comb_and,
  input  logic                         cfg_latch,
  input  logic [NUM_AXES-1:0]          cfg_hi_en,
  input  logic [NUM_AXES-1:0]          cfg_lo_en,
  input  logic [SAMPLE_W-2:0]          thresh,
  input  logic [DUR_W-1:0]             duration,
  input  logic                         irq_active_low,
  input  logic                         src_rd,
  output logic [NUM_AXES-1:0]          src_hi,
  output logic [NUM_AXES-1:0]          src_lo,
  output logic                         src_active,
  output logic                         irq
);
  logic [NUM_AXES-1:0] ev_hi;
  logic [NUM_AXES-1:0] ev_lo;
  logic                cond;
  logic                fire;
  logic                act_n;
  logic                hold;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    axis_evt_t evt;
    ffwu_axis_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
      .sample (smp_data[a*SAMPLE_W +: SAMPLE_W]),
      .thresh (thresh),
      .en_hi  (cfg_hi_en[a]),
      .en_lo  (cfg_lo_en[a]),
      .evt    (evt)
    );
    assign ev_hi[a] = evt.hi;
    assign ev_lo[a] = evt.lo;
  end

  ffwu_combine #(.NUM_AXES(NUM_AXES)) u_comb (
    .ev_hi    (ev_hi),
    .ev_lo    (ev_lo),
    .en_hi    (cfg_hi_en),
    .en_lo    (cfg_lo_en),
    .mode_and (cfg_comb_and),
    .cond     (cond)
  );

  ffwu_dur_qual #(.DUR_W(DUR_W)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .valid (smp_valid),
    .cond  (cond),
    .dur   (duration),
    .fire  (fire)
  );

  assign hold = cfg_latch & src_active;

  always_comb begin
    act_n = src_active;
    if (src_rd && cfg_latch) act_n = 1'b0;
    if (smp_valid) begin
      if (fire)            act_n = 1'b1;
      else if (!cfg_latch) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_hi     <= '0;
      src_lo     <= '0;
      src_active <= 1'b0;
      irq        <= irq_active_low;
    end else begin
      if (smp_valid && !hold) begin
        src_hi <= ev_hi;
        src_lo <= ev_lo;
      end
      src_active <= act_n;
      irq        <= act_n ^ irq_active_low;
    end
  end

  AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (cfg_hi_en == '0 && cfg_lo_en == '0 && !src_active) |=> !src_active) else $error("active without enables"); // R5
  AST_UNLATCHED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !cond && !cfg_latch) |=> !src_active) else $error("active not cleared"); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_latch && src_active && !src_rd) |=> (src_active && $stable(src_hi) && $stable(src_lo))) else $error("latched state lost"); // R8
  AST_IRQ_POLARITY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (src_active ^ $past(irq_active_low)))) else $error("irq polarity"); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !src_rd) |=> ($stable(src_active) && $stable(src_hi) && $stable(src_lo))) else $error("change without sample"); // R10
endmodule

// File: tb/test_ffwu_irq_gen.sv
module test_ffwu_irq_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        cfg_comb_and = 1'b0;
  logic        cfg_latch = 1'b0;
  logic [2:0]  cfg_hi_en = '0;
  logic [2:0]  cfg_lo_en = '0;
  logic [6:0]  thresh = '0;
  logic [7:0]  duration = '0;
  logic        irq_active_low = 1'b0;
  logic        src_rd = 1'b0;
  logic [2:0]  src_hi;
  logic [2:0]  src_lo;
  logic        src_active;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ffwu_irq_gen i_ffwu_irq_gen (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_comb_and(cfg_comb_and), .cfg_latch(cfg_latch), .cfg_hi_en(cfg_hi_en),
    .cfg_lo_en(cfg_lo_en), .thresh(thresh), .duration(duration),
    .irq_active_low(irq_active_low), .src_rd(src_rd), .src_hi(src_hi),
    .src_lo(src_lo), .src_active(src_active), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample(input int x, input int y, input int z);
    @(negedge clk);
    smp_data  = {8'(z), 8'(y), 8'(x)};
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic expect_state(input string req, input int act, input int hi, input int lo);
    chk({req, " active"}, int'(src_active), act);
    chk({req, " hi"}, int'(src_hi), hi);
    chk({req, " lo"}, int'(src_lo), lo);
    chk({req, " irq"}, int'(irq), act ^ int'(irq_active_low));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expect_state("R1", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    expect_state("R1", 0, 0, 0);
  endtask

  task automatic t_compare();
    cfg_comb_and = 1'b0; cfg_latch = 1'b0; duration = 0;
    cfg_hi_en = 3'b111; cfg_lo_en = 3'b000; thresh = 40;
    sample(40, 0, 0);    expect_state("R2 at threshold", 0, 0, 0);
    sample(41, 0, 0);    expect_state("R2 above threshold", 1, 1, 0);
    sample(0, -41, 0);   expect_state("R2 negative", 1, 2, 0);
    sample(0, 0, -40);   expect_state("R7 clear on false", 0, 0, 0);
    thresh = 127;
    sample(-128, 127, 0); expect_state("R2 most negative", 1, 1, 0);
    cfg_hi_en = 3'b000; cfg_lo_en = 3'b111; thresh = 10;
    sample(100, 5, 100); expect_state("R3 OR any low", 1, 0, 2);
    sample(100, 100, -100); expect_state("R3 OR none", 0, 0, 0);
  endtask

  task automatic t_and();
    cfg_comb_and = 1'b1; cfg_hi_en = 3'b000; cfg_lo_en = 3'b111; thresh = 20;
    sample(3, -5, 20);   expect_state("R4 all low", 1, 0, 7);
    sample(3, -21, 0);   expect_state("R4 one high", 0, 0, 5);
    cfg_hi_en = 3'b001; cfg_lo_en = 3'b100;
    sample(50, 0, 5);    expect_state("R4 mixed true", 1, 1, 4);
    sample(50, 0, 30);   expect_state("R4 mixed false", 0, 1, 0);
  endtask

  task automatic t_none();
    cfg_hi_en = 3'b000; cfg_lo_en = 3'b000; thresh = 10;
    cfg_comb_and = 1'b1;
    sample(100, 100, 100); expect_state("R5 AND no enables", 0, 0, 0);
    sample(0, 0, 0);       expect_state("R5 AND no enables low", 0, 0, 0);
    cfg_comb_and = 1'b0;
    sample(100, 0, -100);  expect_state("R5 OR no enables", 0, 0, 0);
  endtask

  task automatic t_duration();
    cfg_comb_and = 1'b0; cfg_hi_en = 3'b001; cfg_lo_en = 3'b000; thresh = 10;
    duration = 3;
    sample(0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      sample(20, 0, 0); expect_state("R6 run short", 0, 1, 0);
    end
    sample(20, 0, 0); expect_state("R6 run complete", 1, 1, 0);
    sample(20, 0, 0); expect_state("R6 run continues", 1, 1, 0);
    sample(0, 0, 0);  expect_state("R6 R7 drop", 0, 0, 0);
    sample(20, 0, 0); sample(20, 0, 0); sample(0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      sample(20, 0, 0); expect_state("R6 restarted run", 0, 1, 0);
    end
    sample(20, 0, 0); expect_state("R6 restarted complete", 1, 1, 0);
    duration = 0;
    sample(0, 0, 0);
  endtask

  task automatic t_latch();
    cfg_latch = 1'b1; cfg_comb_and = 1'b0; cfg_hi_en = 3'b001; thresh = 10;
    sample(0, 0, 0);   expect_state("R8 idle", 0, 0, 0);
    sample(20, 0, 0);  expect_state("R8 trigger", 1, 1, 0);
    sample(0, 0, 0);   expect_state("R8 held", 1, 1, 0);
    sample(-3, 0, 0);  expect_state("R8 still held", 1, 1, 0);
    @(negedge clk); src_rd = 1'b1;
    @(negedge clk); src_rd = 1'b0;
    chk("R8 read clears", int'(src_active), 0);
    sample(0, 0, 0);   expect_state("R8 after read", 0, 0, 0);
    cfg_latch = 1'b0;
  endtask

  task automatic t_polarity();
    cfg_hi_en = 3'b001; thresh = 10;
    @(negedge clk); irq_active_low = 1'b1;
    @(negedge clk);
    chk("R9 idle active-low", int'(irq), 1);
    sample(20, 0, 0); chk("R9 asserted low", int'(irq), 0);
    @(negedge clk); irq_active_low = 1'b0;
    @(negedge clk);
    chk("R9 back to high", int'(irq), 1);
    sample(0, 0, 0);  chk("R9 deasserted", int'(irq), 0);
  endtask

  task automatic t_valid();
    cfg_hi_en = 3'b001; thresh = 10;
    @(negedge clk); smp_data = {8'd100, 8'd100, 8'd100};
    repeat (4) @(negedge clk);
    expect_state("R10 ignored while idle", 0, 0, 0);
    sample(20, 0, 0);
    @(negedge clk); smp_data = '0;
    repeat (4) @(negedge clk);
    expect_state("R10 held without strobe", 1, 1, 0);
    sample(0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_compare();
    t_and();
    t_none();
    t_duration();
    t_latch();
    t_polarity();
    t_valid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule